// File: doc/BRIEF.md
# Line-Cycle Skipping Burst Controller

This block runs a power converter in a light-load burst mode that works in whole AC line cycles. A load estimate is compared with an entry threshold. Once the load is below it, the converter conducts for one full line cycle, then stays off for N whole line cycles, then conducts again. Single PWM pulses are never skipped. N comes from a small programmable table indexed by the quantized load, so a lighter load gives a longer off interval when the table is filled that way. Above the threshold plus a hysteresis margin, the converter runs continuously.

The only output is a converter enable. It changes only in the clock after a zero-crossing strobe, so every on/off edge falls at zero current. One line cycle is the span between two positive-going crossings.

The controller has three states:
- `RUN_CONT`: continuous operation. This is the reset state.
- `SKIP_OFF`: the converter is held off and the off interval is being counted.
- `BURST_ON`: the single conducting cycle between two off intervals.

The transitions are:
- `RUN_CONT`→`SKIP_OFF` on a positive crossing with the load below the threshold.
- `SKIP_OFF`→`BURST_ON` on the positive crossing that ends the Nth skipped cycle.
- `BURST_ON`→`SKIP_OFF` on the next positive crossing.
- `SKIP_OFF`→`RUN_CONT` and `BURST_ON`→`RUN_CONT` on any crossing with the load above the exit level.

Top module: `line_cycle_skipper`

## Requirements
- R1: After reset, `conv_en` is 1 and the controller is in continuous operation.
- R2: `conv_en` changes only in the clock cycle directly after a cycle with `zc_stb` = 1. It never changes otherwise.
- R3: Burst mode is entered only on a positive-going crossing (`zc_pos` = 1) with `load_est` < `thresh`. `conv_en` then drops to 0. A negative crossing never starts burst mode.
- R4: The off interval lasts N positive crossings. `conv_en` returns to 1 on the Nth one. N is the 3-bit field `skip_tbl[3*b+2:3*b]`, where bin b = `load_est[7:6]`.
- R5: A table field of 0 is used as N = 1. The largest N is 7.
- R6: Inside burst mode, after an off interval the converter conducts for exactly one line cycle. At the next positive crossing `conv_en` drops to 0 again with a freshly looked-up N.
- R7: N is latched when an off interval starts. A load change during that interval does not alter its length while the load stays below the exit level.
- R8: At any crossing of either polarity, with `load_est` > `thresh` + `hyst`, the controller leaves burst mode. `conv_en` becomes 1 and stays 1.
- R9: A load between `thresh` and `thresh` + `hyst` keeps the current mode: bursting continues, and continuous operation continues.
- R10: Negative crossings (`zc_pos` = 0) do not advance the off-interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_est | input | 8 | Load estimate, unsigned |
| thresh | input | 8 | Burst entry threshold |
| hyst | input | 8 | Exit margin added to the threshold |
| skip_tbl | input | 12 | Four 3-bit skip counts, one per load bin, bin 0 in bits 2:0 |
| zc_stb | input | 1 | One-cycle zero-crossing strobe |
| zc_pos | input | 1 | Crossing polarity, 1 = positive-going, valid with `zc_stb` |
| conv_en | output | 1 | Converter enable |

## Verification
The assertions assume that `zc_stb` is a single-cycle pulse with `zc_pos` valid alongside it. They also assume that `load_est`, `thresh` and `hyst` are steady in the strobe cycle, so the sampled load is the one the transition used. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It changes the load only between strobes, and sweeps every load bin against every table value from 0 to 7.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    typedef enum logic [1:0] {
        RUN_CONT = 2'd0,
        SKIP_OFF = 2'd1,
        BURST_ON = 2'd2
    } lcs_state_e;
endpackage

// File: rtl/lcs_skip_lookup.sv
module lcs_skip_lookup #(
    parameter int LOAD_W = 8,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic [LOAD_W-1:0]              load_est,
    input  logic [(2**IDX_W)*CNT_W-1:0]    skip_tbl,
    output logic [CNT_W-1:0]               skip_n
);
    localparam int NBINS = 2 ** IDX_W;

    logic [IDX_W-1:0] bin;
    logic [CNT_W-1:0] fields [NBINS];
    logic [CNT_W-1:0] raw;

    assign bin = load_est[LOAD_W-1 -: IDX_W];

    for (genvar g = 0; g < NBINS; g++) begin : g_field
        assign fields[g] = skip_tbl[g*CNT_W +: CNT_W];
    end

    assign raw    = fields[bin];
    assign skip_n = (raw == '0) ? CNT_W'(1) : raw;
endmodule

// File: rtl/lcs_load_compare.sv
module lcs_load_compare #(
    parameter int LOAD_W = 8
) (
    input  logic [LOAD_W-1:0] load_est,
    input  logic [LOAD_W-1:0] thresh,
    input  logic [LOAD_W-1:0] hyst,
    output logic              below_entry,
    output logic              above_exit
);
    logic [LOAD_W:0] exit_level;

    assign exit_level  = {1'b0, thresh} + {1'b0, hyst};
    assign below_entry = load_est < thresh;
    assign above_exit  = {1'b0, load_est} > exit_level;
endmodule

// File: rtl/lcs_cycle_counter.sv
module lcs_cycle_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(1);
        end else if (load_en) begin
            cnt <= load_val;
        end else if (dec_en && cnt > CNT_W'(1)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/line_cycle_skipper.sv
module line_cycle_skipper
    import lcs_pkg::*;
#(
    parameter int LOAD_W = 8,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LOAD_W-1:0]              load_est,
    input  logic [LOAD_W-1:0]              thresh,
    input  logic [LOAD_W-1:0]              hyst,
    input  logic [(2**IDX_W)*CNT_W-1:0]    skip_tbl,
    input  logic                           zc_stb,
    input  logic                           zc_pos,
    output logic                           conv_en
);
    lcs_state_e       state_q, state_d;
    logic [CNT_W-1:0] skip_n;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_last;
    logic             below_entry, above_exit;
    logic             pos_zc, any_zc;
    logic             cnt_load, cnt_dec;

    assign any_zc = zc_stb;
    assign pos_zc = zc_stb && zc_pos;

    lcs_skip_lookup #(.LOAD_W(LOAD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) lookup_i (
        .load_est (load_est),
        .skip_tbl (skip_tbl),
        .skip_n   (skip_n)
    );

    lcs_load_compare #(.LOAD_W(LOAD_W)) cmp_i (
        .load_est    (load_est),
        .thresh      (thresh),
        .hyst        (hyst),
        .below_entry (below_entry),
        .above_exit  (above_exit)
    );

    lcs_cycle_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cnt_load),
        .load_val (skip_n),
        .dec_en   (cnt_dec),
        .cnt      (cnt_q),
        .last     (cnt_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_CONT: begin
                if (pos_zc && below_entry) state_d = SKIP_OFF;
            end
            SKIP_OFF: begin
                if (any_zc && above_exit)      state_d = RUN_CONT;
                else if (pos_zc && cnt_last)   state_d = BURST_ON;
            end
            BURST_ON: begin
                if (any_zc && above_exit)      state_d = RUN_CONT;
                else if (pos_zc)               state_d = SKIP_OFF;
            end
            default: state_d = RUN_CONT;
        endcase
    end

    assign cnt_load = (state_d == SKIP_OFF) && (state_q != SKIP_OFF);
    assign cnt_dec  = (state_q == SKIP_OFF) && pos_zc && !above_exit && !cnt_last;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_CONT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SKIP_OFF: conv_en = 1'b0;
            default:  conv_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/line_cycle_skipper_chk.sv
module line_cycle_skipper_chk #(
    parameter int LOAD_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LOAD_W-1:0] load_est,
    input logic [LOAD_W-1:0] thresh,
    input logic [LOAD_W-1:0] hyst,
    input logic              zc_stb,
    input logic              zc_pos,
    input logic              conv_en,
    input logic [1:0]        state_q,
    input logic [CNT_W-1:0]  cnt_q
);
    localparam logic [1:0] S_RUN = 2'd0;
    localparam logic [1:0] S_OFF = 2'd1;
    localparam logic [1:0] S_ON  = 2'd2;

    // R2
    en_edge_at_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en != $past(conv_en)) |-> $past(zc_stb));

    // R3
    entry_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && $past(state_q) == S_RUN)
            |-> $past(zc_pos && (load_est < thresh)));

    // R8
    exit_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && $past(state_q) != S_RUN)
            |-> $past({1'b0, load_est} > ({1'b0, thresh} + {1'b0, hyst})));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |-> (cnt_q != '0));

    // R6
    on_ends_at_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_ON && state_q == S_OFF) |-> $past(zc_stb && zc_pos));

    // R10
    neg_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_OFF && state_q == S_OFF && !$past(zc_pos))
            |-> (cnt_q == $past(cnt_q)));
endmodule

bind line_cycle_skipper line_cycle_skipper_chk #(.LOAD_W(LOAD_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_est (load_est),
    .thresh   (thresh),
    .hyst     (hyst),
    .zc_stb   (zc_stb),
    .zc_pos   (zc_pos),
    .conv_en  (conv_en),
    .state_q  (state_q),
    .cnt_q    (cnt_q)
);

// File: tb/line_cycle_skipper_tb_top.sv
module line_cycle_skipper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  load_est = 8'd0;
    logic [7:0]  thresh = 8'd200;
    logic [7:0]  hyst = 8'd20;
    logic [11:0] skip_tbl = 12'hFFF;
    logic        zc_stb = 1'b0;
    logic        zc_pos = 1'b0;
    logic        conv_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_cycle_skipper dut_i (
        .clk(clk), .rst_n(rst_n), .load_est(load_est), .thresh(thresh),
        .hyst(hyst), .skip_tbl(skip_tbl), .zc_stb(zc_stb), .zc_pos(zc_pos),
        .conv_en(conv_en)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: conv_en=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        zc_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // strobe for one cycle; output is sampled on the falling edge after the capturing edge
    task automatic zc(input logic pos);
        zc_stb = 1'b1;
        zc_pos = pos;
        @(negedge clk);
        zc_stb = 1'b0;
        zc_pos = 1'b0;
    endtask

    function automatic logic [11:0] table_with(input int bin, input int val, input int others);
        logic [11:0] t = '0;
        for (int i = 0; i < 4; i++) t[i*3 +: 3] = 3'(others);
        t[bin*3 +: 3] = 3'(val);
        return t;
    endfunction

    initial begin
        do_reset();
        check(conv_en, 1'b1, "R1");

        // Sweep every bin against every table value (R3, R4, R5, R6, R10)
        for (int b = 0; b < 4; b++) begin
            for (int v = 0; v < 8; v++) begin
                int n_eff;
                n_eff = (v == 0) ? 1 : v;
                skip_tbl = table_with(b, v, 7);
                load_est = 8'(b * 64 + 5);
                do_reset();
                check(conv_en, 1'b1, "R1");
                zc(1'b0);
                check(conv_en, 1'b1, "R3");
                zc(1'b1);
                check(conv_en, 1'b0, "R3");
                for (int k = 1; k <= n_eff; k++) begin
                    zc(1'b0);
                    check(conv_en, 1'b0, "R10");
                    zc(1'b1);
                    check(conv_en, (k == n_eff), (v == 0) ? "R5" : "R4");
                end
                zc(1'b0);
                check(conv_en, 1'b1, "R6");
                zc(1'b1);
                check(conv_en, 1'b0, "R6");
            end
        end

        // R7: count latched at start of off interval
        skip_tbl = 12'h0;
        skip_tbl[2:0] = 3'd2;
        skip_tbl[5:3] = 3'd5;
        load_est = 8'd10;
        do_reset();
        zc(1'b1);
        check(conv_en, 1'b0, "R7");
        load_est = 8'd70;
        zc(1'b0); zc(1'b1);
        check(conv_en, 1'b0, "R7");
        zc(1'b0); zc(1'b1);
        check(conv_en, 1'b1, "R7");
        zc(1'b0);
        zc(1'b1);
        check(conv_en, 1'b0, "R7");
        for (int k = 1; k <= 5; k++) begin
            zc(1'b0);
            zc(1'b1);
            check(conv_en, (k == 5), "R7");
        end

        // R8 / R9 / R3 / R2
        skip_tbl = 12'b011_011_011_011;
        load_est = 8'd100;
        do_reset();
        zc(1'b1);
        check(conv_en, 1'b0, "R3");
        load_est = 8'd230;
        zc(1'b0);
        check(conv_en, 1'b1, "R8");
        load_est = 8'd210;
        zc(1'b1);
        check(conv_en, 1'b1, "R9");
        zc(1'b0);
        check(conv_en, 1'b1, "R9");
        load_est = 8'd100;
        zc(1'b0);
        check(conv_en, 1'b1, "R3");
        zc(1'b1);
        check(conv_en, 1'b0, "R3");
        load_est = 8'd210;
        for (int k = 1; k <= 3; k++) begin
            zc(1'b1);
            check(conv_en, (k == 3), "R9");
        end
        zc(1'b1);
        check(conv_en, 1'b0, "R9");
        load_est = 8'd250;
        repeat (3) @(negedge clk);
        check(conv_en, 1'b0, "R2");
        zc(1'b0);
        check(conv_en, 1'b1, "R8");
        zc(1'b1);
        check(conv_en, 1'b1, "R8");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, got timeout expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule